// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable synchronous SRAM. Reads and writes share one fixed latency, so they can follow each other on consecutive clock cycles with no idle slot between them. Address and control are captured on a rising edge. The data for that operation moves two edges later. For a read, the word leaves the output register after that edge. For a write, the word on `din` is captured at that edge.

A host starts an operation with a load cycle, which carries the chip enables, the direction and an external address. It can then continue with up to three advance cycles. On each advance cycle an internal two-bit counter steps the low address bits in linear or interleaved order. The bus is modelled as separate `din`, `dout` and `dout_en` ports. `dout_en` is the tri-state enable an I/O pad would use. It is gated asynchronously by an active-low output enable and is forced off in sleep mode. An active-low clock enable makes the block ignore an edge completely.

Top module: `zt_sram`

## Requirements
- R1: A load cycle with the chip selected and `wr_n`=1 at edge N (no stalls) puts the addressed word on `dout` after edge N+2, and `dout_en` is 1 for that cycle when `oe_n`=0.
- R2: A load cycle with the chip selected and `wr_n`=0 at edge N stores the `din` value that is present at edge N+2, and later reads return it.
- R3: The chip is selected only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1. A load cycle with any other combination is a deselect, and `dout_en` is 0 in its data slot.
- R4: `dout_en` is 0 in the data slot of a write. Reads and writes to the same address may alternate every cycle, and each read returns every earlier write.
- R5: While `clken_n`=1, an edge has no effect. The pipeline, the burst counter, the memory and `dout` all keep their values, and the sequence resumes unchanged once `clken_n`=0.
- R6: `advance`=1 continues the operation that was last loaded, with the same direction whatever `wr_n` now shows. The upper address bits stay those of the loaded address. After a deselect load, advance cycles stay deselected.
- R7: In linear order (`burst_ilv`=0 at the load cycle), the k-th advance uses low bits (base+k) mod 4. The fourth advance returns to the base address.
- R8: In interleaved order (`burst_ilv`=1 at the load cycle), the k-th advance uses low bits base XOR (k mod 4). The order is latched at the load cycle.
- R9: Each 9-bit lane i (`din[9i+8:9i]`) has an active-low write enable `lane_wr_n[i]`. These enables are sampled on every cycle, advance cycles included, and a write changes only the enabled lanes.
- R10: `oe_n`=1 forces `dout_en` to 0 at once, with no clock edge needed.
- R11: While `sleep`=1, `dout_en` is 0 and no memory write takes place. Operations in flight are discarded, and after sleep ends `dout_en` stays 0 until a new read reaches its data slot.
- R12: A synchronous reset (`rst`=1) clears the pipeline, sets `dout` to 0 and `dout_en` to 0, and ends any burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clken_n | input | 1 | Active-low clock enable; 1 ignores the edge |
| advance | input | 1 | 0 loads a new address and operation, 1 advances the burst |
| sel_a_n | input | 1 | Chip enable, active low |
| sel_b_n | input | 1 | Chip enable, active low |
| sel_c | input | 1 | Chip enable, active high |
| wr_n | input | 1 | Direction at load: 0 write, 1 read |
| lane_wr_n | input | LANES (4) | Per-lane write enables, active low |
| burst_ilv | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| addr | input | log2(DEPTH) (6) | Word address |
| din | input | LANES*LANE_W (36) | Write data, sampled in the write data slot |
| dout | output | LANES*LANE_W (36) | Registered read data |
| dout_en | output | 1 | Bus drive enable for `dout` |

## Verification
If the burst counter or its base register is wrong, the fault stays hidden while the data is written. It appears only when a later read lands on a word the model did not expect, so bursts are read back both by burst and by single-word access. An error in the pipeline stages shows within two cycles as a `dout_en` pulse in the wrong slot. A lost clock-enable hold shows on the very next cycle as a `dout` change while the block is stalled. A missed sleep flush shows as a bus drive right after wake-up.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } zt_op_e;

  localparam int unsigned BURST_LEN = 4;
  localparam int unsigned BURST_W   = $clog2(BURST_LEN);

  // Low address bits for step k of a burst from base.
  function automatic logic [BURST_W-1:0] burst_lo(
    input logic [BURST_W-1:0] base,
    input logic [BURST_W-1:0] k,
    input logic               ilv
  );
    return ilv ? (base ^ k) : (base + k);
  endfunction
endpackage

// File: rtl/zt_burst_addr.sv
module zt_burst_addr
  import zt_sram_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          flush,
  input  logic          load,
  input  logic          sel,
  input  logic          wr_n,
  input  logic          ilv,
  input  logic [AW-1:0] addr_in,
  output zt_op_e        op_o,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0]      base_q;
  logic [BURST_W-1:0] cnt_q;
  logic [BURST_W-1:0] cnt_nxt;
  logic               ilv_q;
  zt_op_e             op_q;

  assign cnt_nxt = cnt_q + 1'b1;

  always_comb begin
    if (load) begin
      op_o   = sel ? (wr_n ? OP_READ : OP_WRITE) : OP_IDLE;
      addr_o = addr_in;
    end else begin
      op_o   = op_q;
      addr_o = {base_q[AW-1:BURST_W], burst_lo(base_q[BURST_W-1:0], cnt_nxt, ilv_q)};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_IDLE;
      base_q <= '0;
      cnt_q  <= '0;
      ilv_q  <= 1'b0;
    end else if (flush) begin
      op_q   <= OP_IDLE;
    end else if (step) begin
      if (load) begin
        op_q   <= op_o;
        base_q <= addr_in;
        cnt_q  <= '0;
        ilv_q  <= ilv;
      end else begin
        cnt_q  <= cnt_nxt;
      end
    end
  end
endmodule

// File: rtl/zt_lane_mem.sv
module zt_lane_mem #(
  parameter int unsigned AW    = 6,
  parameter int unsigned LW    = 9,
  parameter int unsigned DEPTH = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [LW-1:0] wd,
  output logic [LW-1:0] rd
);
  logic [LW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en && we) mem[addr] <= wd;
  end

  always_ff @(posedge clk) begin
    if (rst)     rd <= '0;
    else if (en) rd <= mem[addr];
  end
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned W     = LANES * LANE_W,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clken_n,
  input  logic             advance,
  input  logic             sel_a_n,
  input  logic             sel_b_n,
  input  logic             sel_c,
  input  logic             wr_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic             burst_ilv,
  input  logic             oe_n,
  input  logic             sleep,
  input  logic [AW-1:0]    addr,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout,
  output logic             dout_en
);
  logic             step;
  logic             selected;
  zt_op_e           cur_op;
  logic [AW-1:0]    cur_addr;
  zt_op_e           s1_op,   s2_op;
  logic [AW-1:0]    s1_addr, s2_addr;
  logic [LANES-1:0] s1_ln,   s2_ln;
  logic             drv_q;
  logic             wr_slot;

  assign step     = ~clken_n & ~sleep;
  assign selected = ~sel_a_n & ~sel_b_n & sel_c;
  assign wr_slot  = (s2_op == OP_WRITE);

  zt_burst_addr #(.AW(AW)) u_burst (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .flush   (sleep),
    .load    (~advance),
    .sel     (selected),
    .wr_n    (wr_n),
    .ilv     (burst_ilv),
    .addr_in (addr),
    .op_o    (cur_op),
    .addr_o  (cur_addr)
  );

  always_ff @(posedge clk) begin
    if (rst || sleep) begin
      s1_op   <= OP_IDLE;
      s2_op   <= OP_IDLE;
      s1_addr <= '0;
      s2_addr <= '0;
      s1_ln   <= '1;
      s2_ln   <= '1;
    end else if (step) begin
      s1_op   <= cur_op;
      s1_addr <= cur_addr;
      s1_ln   <= lane_wr_n;
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_ln   <= s1_ln;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || sleep) drv_q <= 1'b0;
    else if (step)    drv_q <= (s2_op == OP_READ);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    zt_lane_mem #(.AW(AW), .LW(LANE_W), .DEPTH(DEPTH)) u_mem (
      .clk  (clk),
      .rst  (rst),
      .en   (step),
      .we   (wr_slot & ~s2_ln[g]),
      .addr (s2_addr),
      .wd   (din[g*LANE_W +: LANE_W]),
      .rd   (dout[g*LANE_W +: LANE_W])
    );
  end

  assign dout_en = drv_q & ~oe_n & ~sleep;
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned W     = LANES * LANE_W
) (
  input logic         clk,
  input logic         rst,
  input logic         clken_n,
  input logic         advance,
  input logic         sel_a_n,
  input logic         sel_b_n,
  input logic         sel_c,
  input logic         wr_n,
  input logic         oe_n,
  input logic         sleep,
  input logic [W-1:0] dout,
  input logic         dout_en
);
  logic go, on, rd_ld, wr_ld, idle_ld;
  assign go      = !clken_n && !sleep;
  assign on      = !sel_a_n && !sel_b_n && sel_c;
  assign rd_ld   = !advance && on && wr_n;
  assign wr_ld   = !advance && on && !wr_n;
  assign idle_ld = !advance && !on;

  a_r1_read_slot: assert property (@(posedge clk) disable iff (rst)
    (rd_ld && go) ##1 go ##1 go |=> (dout_en || oe_n || sleep));

  a_r3_deselect_slot: assert property (@(posedge clk) disable iff (rst)
    (idle_ld && go) ##1 go ##1 go |=> !dout_en);

  a_r4_write_slot: assert property (@(posedge clk) disable iff (rst)
    (wr_ld && go) ##1 go ##1 go |=> !dout_en);

  a_r5_hold_dout: assert property (@(posedge clk) disable iff (rst)
    (clken_n && !sleep) |=> $stable(dout));

  a_r10_oe_gate: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !dout_en);

  a_r11_sleep_quiet: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !dout_en);

  a_r11_wake_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(sleep) |-> !dout_en);

  a_r12_reset_clear: assert property (@(posedge clk)
    rst |=> (!dout_en && dout == '0));
endmodule

bind zt_sram zt_sram_chk #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) i_chk (
  .clk     (clk),
  .rst     (rst),
  .clken_n (clken_n),
  .advance (advance),
  .sel_a_n (sel_a_n),
  .sel_b_n (sel_b_n),
  .sel_c   (sel_c),
  .wr_n    (wr_n),
  .oe_n    (oe_n),
  .sleep   (sleep),
  .dout    (dout),
  .dout_en (dout_en)
);

// File: tb/test_zt_sram.sv
module test_zt_sram;
  localparam int LANES = 4;
  localparam int LW    = 9;
  localparam int DEPTH = 64;
  localparam int W     = LANES * LW;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst, clken_n, advance, sel_a_n, sel_b_n, sel_c, wr_n, burst_ilv, oe_n, sleep;
  logic [LANES-1:0] lane_wr_n;
  logic [AW-1:0]    addr;
  logic [W-1:0]     din;
  logic [W-1:0]     dout;
  logic             dout_en;

  always #5 clk = ~clk;

  zt_sram #(.LANES(LANES), .LANE_W(LW), .DEPTH(DEPTH)) i_zt_sram (
    .clk(clk), .rst(rst), .clken_n(clken_n), .advance(advance),
    .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c), .wr_n(wr_n),
    .lane_wr_n(lane_wr_n), .burst_ilv(burst_ilv), .oe_n(oe_n), .sleep(sleep),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string ctag = "";

  // Reference model: op codes 0 idle, 1 read, 2 write
  logic [W-1:0]  ref_mem [DEPTH];
  int            p1_op, p2_op, m_op, slot_op;
  logic [AW-1:0] p1_a, p2_a, m_base;
  logic [3:0]    p1_ln, p2_ln;
  logic [1:0]    m_cnt;
  bit            m_ilv, e_drv;
  logic [W-1:0]  e_dout;

  task automatic chk(string tag, bit ok, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] order(logic [1:0] b, logic [1:0] k, bit ilv);
    return ilv ? (b ^ k) : (b + k);
  endfunction

  task automatic model_edge();
    int            cop;
    logic [AW-1:0] ca;
    logic [1:0]    nc;
    bit            on;
    if (rst) begin
      p1_op = 0; p2_op = 0; m_op = 0; m_base = '0; m_cnt = '0; m_ilv = 0;
      e_drv = 0; e_dout = '0; slot_op = 0;
    end else if (sleep) begin
      p1_op = 0; p2_op = 0; m_op = 0; e_drv = 0;
    end else if (!clken_n) begin
      slot_op = p2_op;
      e_drv = (p2_op == 1);
      if (p2_op == 1) e_dout = ref_mem[p2_a];
      if (p2_op == 2)
        for (int i = 0; i < LANES; i++)
          if (!p2_ln[i]) ref_mem[p2_a][i*LW +: LW] = din[i*LW +: LW];
      on = !sel_a_n && !sel_b_n && sel_c;
      if (!advance) begin
        cop = on ? (wr_n ? 1 : 2) : 0;
        ca = addr;
        m_base = addr; m_cnt = '0; m_ilv = burst_ilv; m_op = cop;
      end else begin
        nc = m_cnt + 2'd1;
        cop = m_op;
        ca = {m_base[AW-1:2], order(m_base[1:0], nc, m_ilv)};
        m_cnt = nc;
      end
      p2_op = p1_op; p2_a = p1_a; p2_ln = p1_ln;
      p1_op = cop;   p1_a = ca;   p1_ln = lane_wr_n;
    end
  endtask

  task automatic check_outs();
    bit    exp_en;
    string tag;
    exp_en = e_drv && !oe_n && !sleep;
    tag = (ctag != "") ? ctag : (slot_op == 1 ? "R1" : (slot_op == 2 ? "R4" : "R3"));
    chk(tag, dout_en === exp_en, W'(dout_en), W'(exp_en));
    if (exp_en) chk(tag, dout === e_dout, dout, e_dout);
  endtask

  task automatic cycle();
    @(posedge clk);
    model_edge();
    #2;
    check_outs();
  endtask

  task automatic put(bit adv, bit on, bit wr, int a, logic [3:0] ln, bit ilv);
    advance = adv;
    if (on) {sel_a_n, sel_b_n, sel_c} = 3'b001;
    else    {sel_a_n, sel_b_n, sel_c} = 3'b101;
    wr_n = !wr; addr = a[AW-1:0]; lane_wr_n = ln; burst_ilv = ilv;
    din = W'({$urandom(), $urandom()});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin put(0, 0, 0, 0, 4'hF, 0); cycle(); end
  endtask

  task automatic read1(int a);
    put(0, 1, 0, a, 4'hF, 0); cycle();
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1; clken_n = 0; oe_n = 0; sleep = 0;
    put(0, 0, 0, 0, 4'hF, 0);
    ctag = "R12";
    for (int i = 0; i < 3; i++) cycle();
    chk("R12", dout === '0, dout, '0);
    chk("R12", dout_en === 1'b0, W'(dout_en), '0);
    rst = 0;

    // Fill the whole array with linear write bursts (R2)
    ctag = "R2";
    for (int b = 0; b < DEPTH / 4; b++) begin
      put(0, 1, 1, 4 * b, 4'h0, 0); cycle();
      for (int k = 0; k < 3; k++) begin put(1, 0, 0, 0, 4'h0, 0); cycle(); end
    end
    idle(2);
    ctag = "R1";
    for (int a = 0; a < DEPTH; a += 7) read1(a);
    idle(3);

    // Lane enables, including a change during a burst (R9)
    ctag = "R9";
    put(0, 1, 1, 10, 4'b1010, 0); cycle();
    put(1, 0, 0, 0, 4'b0110, 0); cycle();
    idle(2);
    read1(10); read1(11); idle(3);

    // Linear burst from low bits 2 with wrap (R7)
    ctag = "R7";
    put(0, 1, 1, 22, 4'h0, 0); cycle();
    for (int k = 0; k < 4; k++) begin put(1, 0, 0, 0, 4'h0, 1); cycle(); end
    idle(2);
    for (int a = 20; a < 24; a++) read1(a);
    idle(3);
    put(0, 1, 0, 22, 4'hF, 0); cycle();
    for (int k = 0; k < 4; k++) begin put(1, 0, 0, 0, 4'hF, 1); cycle(); end
    idle(3);

    // Interleaved burst, mode latched at load (R8)
    ctag = "R8";
    put(0, 1, 1, 33, 4'h0, 1); cycle();
    for (int k = 0; k < 3; k++) begin put(1, 0, 0, 0, 4'h0, 0); cycle(); end
    idle(2);
    for (int a = 32; a < 36; a++) read1(a);
    idle(3);

    // Burst keeps direction; advance after deselect stays idle (R6)
    ctag = "R6";
    put(0, 1, 1, 40, 4'h0, 0); cycle();
    for (int k = 0; k < 3; k++) begin put(1, 1, 0, 0, 4'h0, 0); cycle(); end
    put(0, 0, 1, 44, 4'h0, 0); cycle();
    for (int k = 0; k < 3; k++) begin put(1, 1, 1, 0, 4'h0, 0); cycle(); end
    idle(2);
    for (int a = 40; a < 48; a++) read1(a);
    idle(3);

    // Clock enable freezes everything mid-burst (R5)
    ctag = "R5";
    put(0, 1, 0, 48, 4'hF, 0); cycle();
    put(1, 0, 0, 0, 4'hF, 0); cycle();
    clken_n = 1;
    put(0, 1, 1, 48, 4'h0, 0);
    for (int i = 0; i < 3; i++) cycle();
    clken_n = 0;
    put(1, 0, 0, 0, 4'hF, 0); cycle();
    clken_n = 1; cycle(); cycle();
    clken_n = 0;
    idle(3);
    read1(48); idle(3);

    // Asynchronous output enable (R10)
    ctag = "R10";
    read1(5); idle(2);
    oe_n = 1; #1;
    chk("R10", dout_en === 1'b0, W'(dout_en), '0);
    oe_n = 0; #1;
    chk("R10", dout_en === 1'b1, W'(dout_en), W'(1));
    idle(2);

    // Sleep: deselect, sleep with attempted writes, wake quiet (R11)
    ctag = "R11";
    read1(5); idle(1);
    sleep = 1;
    put(0, 1, 1, 5, 4'h0, 0);
    for (int i = 0; i < 3; i++) cycle();
    sleep = 0;
    idle(3);
    read1(5); idle(3);

    // Back-to-back alternation at one address (R4)
    ctag = "R4";
    for (int i = 0; i < 6; i++) begin put(0, 1, (i % 2) == 0, 60, 4'h0, 0); cycle(); end
    idle(3);

    // Constrained random mix
    ctag = "";
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      put(r < 45, 1, $urandom_range(0, 1) == 1, int'($urandom_range(0, DEPTH - 1)),
          4'($urandom()), $urandom_range(0, 1) == 1);
      if ($urandom_range(0, 7) == 0) begin
        logic [2:0] s;
        s = 3'($urandom());
        if (s == 3'b001) s = 3'b011;
        {sel_a_n, sel_b_n, sel_c} = s;
      end
      clken_n = ($urandom_range(0, 7) == 0);
      oe_n    = ($urandom_range(0, 9) == 0);
      cycle();
    end
    clken_n = 0; oe_n = 0;
    idle(3);
    report();
  end
endmodule